// File: doc/BRIEF.md
# Level-Two Cache Configuration Register Bank

This block holds the software-visible configuration of a level-two cache controller. It has no cache arrays and does no cache maintenance. A simple 32-bit register bus drives it, with an address, a write strobe, write data and a read strobe. Read data comes back on the following clock edge.

Only the low twelve address bits are decoded, so the bank fills a 4 KB window that repeats across the rest of the address space. The bank holds six values:

- an enable bit;
- an auxiliary configuration word;
- two RAM-latency words;
- a pair of address-filter bounds.

Two read-only words are also visible. One is a fixed identity constant. The other is a cache-geometry word, built at read time from a parameter base and from geometry bits taken out of the auxiliary word.

A maintenance window and three isolated maintenance offsets take any access quietly and have no effect. Any other unmapped access reads as zero, changes nothing and raises a one-cycle `bad_access` pulse. A write to either read-only word also counts as a bad access.

Top module: `l2cfg_regbank`

## Requirements
- R1: Only `bus_addr[11:0]` selects a register. An access whose low twelve bits match a mapped offset behaves the same whatever the upper address bits are.
- R2: Reading offset 0x000 returns `ID_WORD` (default 0x410000C8). A write there changes nothing and raises `bad_access`.
- R3: Offset 0x100 holds one enable bit, written from `bus_wdata[0]`. It reads back in bit 0, and bits 31:1 always read as zero.
- R4: The following offsets each store a full 32-bit word and return it on read: 0x104 auxiliary, 0x108 tag latency, 0x10C data latency, 0xC00 filter low bound, 0xC04 filter high bound. A stored word changes only on a write to its own offset.
- R5: After reset, the auxiliary word is `AUX_RESET` (default 0x02020000). The enable bit, both latency words and both filter bounds are zero. `bus_rdata` and `bad_access` are also zero.
- R6: Reading offset 0x004 returns `CTYPE_BASE` (default 0x1C100100) ORed with a 5-bit field G placed at bit 18 and again at bit 6. G[4:2] = aux[19:17], G[1] = 0 and G[0] = aux[16]. The value is recomputed on every read and never accumulates: the result follows the current auxiliary word only.
- R7: Offsets 0x730 to 0x7FF read as zero. Writes to them have no effect, and they never raise `bad_access`.
- R8: Offsets 0xF40, 0xF60 and 0xF80 read as zero. Writes to them have no effect, and they never raise `bad_access`.
- R9: Any other offset reads as zero and ignores writes. `bad_access` is high for exactly the one cycle after a bad access.
- R10: `bus_rdata` updates on the clock edge that samples `bus_rd` and holds its value while `bus_rd` is low. A read and a write to the same register in one cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; only bits 11:0 are decoded |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| bad_access | output | 1 | One-cycle flag for an unmapped access |

## Verification
The embedded properties check on every cycle that:
- a stored word moves only on a write to its own slot;
- the enable register never shows upper bits;
- identity and maintenance reads return their fixed values;
- quiet offsets never flag;
- read data holds while no read is issued.

Only the bench scenarios can show the full register map: values surviving across many accesses, address aliasing, the geometry packing following later auxiliary writes without sticking, and old-value return when a read and a write collide. These are compared against a reference model kept in the bench.

// File: rtl/l2cfg_pkg.sv
package l2cfg_pkg;

   localparam int unsigned OFS_W     = 12;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned NUM_STORE = 5;
   localparam int unsigned SLOT_AUX  = 0;
   localparam int unsigned GEOM_W    = 5;

   typedef enum logic [3:0] {
      RG_ID,
      RG_CTYPE,
      RG_CTRL,
      RG_AUX,
      RG_TAG,
      RG_DATA,
      RG_FLO,
      RG_FHI,
      RG_MAINT,
      RG_HOLE
   } region_e;

   // Storage slot to region mapping for the full-width words
   function automatic region_e slot_region(input int unsigned idx);
      case (idx)
         0:       return RG_AUX;
         1:       return RG_TAG;
         2:       return RG_DATA;
         3:       return RG_FLO;
         default: return RG_FHI;
      endcase
   endfunction

   // Geometry field: way size in bits 4:2, associativity in bit 0
   function automatic logic [GEOM_W-1:0] pack_geom(input logic [WORD_W-1:0] aux);
      return {aux[19:17], 1'b0, aux[16]};
   endfunction

endpackage

// File: rtl/l2cfg_decode.sv
module l2cfg_decode
   import l2cfg_pkg::*;
(
   input  logic [OFS_W-1:0] ofs,
   input  logic             rd,
   input  logic             wr,
   output region_e          region,
   output logic             bad
);

   logic rd_ok;
   logic wr_ok;

   always_comb begin
      region = RG_HOLE;
      if (ofs >= 12'h730 && ofs <= 12'h7FF) begin
         region = RG_MAINT;
      end else begin
         case (ofs)
            12'h000: region = RG_ID;
            12'h004: region = RG_CTYPE;
            12'h100: region = RG_CTRL;
            12'h104: region = RG_AUX;
            12'h108: region = RG_TAG;
            12'h10C: region = RG_DATA;
            12'hC00: region = RG_FLO;
            12'hC04: region = RG_FHI;
            12'hF40, 12'hF60, 12'hF80: region = RG_MAINT;
            default: region = RG_HOLE;
         endcase
      end
   end

   always_comb begin
      rd_ok = (region != RG_HOLE);
      wr_ok = rd_ok && (region != RG_ID) && (region != RG_CTYPE);
      bad   = (rd && !rd_ok) || (wr && !wr_ok);
   end

endmodule

// File: rtl/l2cfg_store.sv
module l2cfg_store
   import l2cfg_pkg::*;
#(
   parameter logic [WORD_W-1:0] AUX_RESET = 32'h0202_0000
)(
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr,
   input  region_e                          region,
   input  logic [WORD_W-1:0]                wdata,
   output logic                             ctrl_en,
   output logic [NUM_STORE-1:0][WORD_W-1:0] store_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_en <= 1'b0;
      end else if (wr && region == RG_CTRL) begin
         ctrl_en <= wdata[0];
      end
   end

   AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && region == RG_CTRL) |=> $stable(ctrl_en))
      else $error("enable bit moved without a write"); // R3

   for (genvar i = 0; i < NUM_STORE; i++) begin : g_slot
      localparam region_e           SLOT = slot_region(i);
      localparam logic [WORD_W-1:0] RST  = (SLOT == RG_AUX) ? AUX_RESET : '0;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            store_q[i] <= RST;
         end else if (wr && region == SLOT) begin
            store_q[i] <= wdata;
         end
      end

      AST_SLOT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr && region == SLOT) |=> $stable(store_q[i]))
         else $error("stored word moved without its own write"); // R4
   end

endmodule

// File: rtl/l2cfg_rdmux.sv
module l2cfg_rdmux
   import l2cfg_pkg::*;
#(
   parameter logic [WORD_W-1:0] ID_WORD    = 32'h4100_00C8,
   parameter logic [WORD_W-1:0] CTYPE_BASE = 32'h1C10_0100
)(
   input  region_e                          region,
   input  logic                             ctrl_en,
   input  logic [NUM_STORE-1:0][WORD_W-1:0] store_q,
   output logic [WORD_W-1:0]                word
);

   localparam int unsigned HI_POS = 18;
   localparam int unsigned LO_POS = 6;

   logic [GEOM_W-1:0] geom;
   logic [WORD_W-1:0] geom_w;
   logic [WORD_W-1:0] ctype;

   always_comb begin
      geom   = pack_geom(store_q[SLOT_AUX]);
      geom_w = {{(WORD_W-GEOM_W){1'b0}}, geom};
      ctype  = CTYPE_BASE | (geom_w << HI_POS) | (geom_w << LO_POS);
   end

   always_comb begin
      word = '0;
      case (region)
         RG_ID:    word = ID_WORD;
         RG_CTYPE: word = ctype;
         RG_CTRL:  word = {{(WORD_W-1){1'b0}}, ctrl_en};
         default: begin
            for (int k = 0; k < NUM_STORE; k++) begin
               if (region == slot_region(k)) word = store_q[k];
            end
         end
      endcase
   end

endmodule

// File: rtl/l2cfg_regbank.sv
module l2cfg_regbank
   import l2cfg_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 32,
   parameter logic [31:0]       ID_WORD    = 32'h4100_00C8,
   parameter logic [31:0]       CTYPE_BASE = 32'h1C10_0100,
   parameter logic [31:0]       AUX_RESET  = 32'h0202_0000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   output logic              bad_access
);

   if (ADDR_W < OFS_W) begin : g_chk_addr
      $error("ADDR_W must cover the 12-bit register window");
   end
   if (WORD_W != 32) begin : g_chk_word
      $error("register words must be 32 bits wide");
   end

   logic [OFS_W-1:0] ofs;
   assign ofs = bus_addr[OFS_W-1:0];

   if (ADDR_W > OFS_W) begin : g_hi
      logic hi_unused;
      assign hi_unused = ^bus_addr[ADDR_W-1:OFS_W];
   end

   region_e                          region;
   logic                             bad;
   logic                             ctrl_en;
   logic [NUM_STORE-1:0][WORD_W-1:0] store_q;
   logic [WORD_W-1:0]                word;

   l2cfg_decode i_decode (
      .ofs    (ofs),
      .rd     (bus_rd),
      .wr     (bus_wr),
      .region (region),
      .bad    (bad)
   );

   l2cfg_store #(
      .AUX_RESET (AUX_RESET)
   ) i_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_wr),
      .region  (region),
      .wdata   (bus_wdata),
      .ctrl_en (ctrl_en),
      .store_q (store_q)
   );

   l2cfg_rdmux #(
      .ID_WORD    (ID_WORD),
      .CTYPE_BASE (CTYPE_BASE)
   ) i_rdmux (
      .region  (region),
      .ctrl_en (ctrl_en),
      .store_q (store_q),
      .word    (word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bad_access <= 1'b0;
      end else begin
         bad_access <= bad;
         if (bus_rd) bus_rdata <= word;
      end
   end

   AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && ofs == 12'h000) |=> (bus_rdata == ID_WORD))
      else $error("identity read mismatch"); // R2

   AST_CTRL_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && ofs == 12'h100) |=> (bus_rdata[31:1] == '0))
      else $error("enable register upper bits set"); // R3

   AST_MAINT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rd || bus_wr) && ofs >= 12'h730 && ofs <= 12'h7FF) |=> !bad_access)
      else $error("maintenance window flagged"); // R7

   AST_MAINT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && ofs >= 12'h730 && ofs <= 12'h7FF) |=> (bus_rdata == '0))
      else $error("maintenance window read nonzero"); // R7

   AST_FIXED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rd || bus_wr) && (ofs == 12'hF40 || ofs == 12'hF60 || ofs == 12'hF80))
      |=> (!bad_access && (!$past(bus_rd) || bus_rdata == '0)))
      else $error("maintenance offset misbehaved"); // R8

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata))
      else $error("read data moved without a read"); // R10

endmodule

// File: tb/test_l2cfg_regbank.sv
`timescale 1ns/1ps
module test_l2cfg_regbank;

   localparam logic [31:0] ID_W  = 32'h4100_00C8;
   localparam logic [31:0] CT_B  = 32'h1C10_0100;
   localparam logic [31:0] AUX_R = 32'h0202_0000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] bus_addr;
   logic        bus_wr;
   logic [31:0] bus_wdata;
   logic        bus_rd;
   logic [31:0] bus_rdata;
   logic        bad_access;

   always #2.5 clk = ~clk;

   l2cfg_regbank i_l2cfg_regbank (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .bus_rd     (bus_rd),
      .bus_rdata  (bus_rdata),
      .bad_access (bad_access)
   );

   int unsigned n_chk  = 0;
   int unsigned n_fail = 0;
   bit          done   = 0;

   // reference model
   logic        m_ctrl;
   logic [31:0] m_aux, m_tag, m_data, m_flo, m_fhi;
   logic [31:0] last_rd;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit is_maint(input logic [11:0] o);
      return (o >= 12'h730 && o <= 12'h7FF) || o == 12'hF40 || o == 12'hF60 || o == 12'hF80;
   endfunction

   function automatic bit is_store(input logic [11:0] o);
      return o == 12'h100 || o == 12'h104 || o == 12'h108 || o == 12'h10C ||
             o == 12'hC00 || o == 12'hC04;
   endfunction

   function automatic logic [31:0] exp_ctype(input logic [31:0] aux);
      logic [31:0] g;
      g = {27'b0, aux[19], aux[18], aux[17], 1'b0, aux[16]};
      return CT_B | (g << 18) | (g << 6);
   endfunction

   function automatic logic [31:0] exp_read(input logic [11:0] o);
      case (o)
         12'h000: return ID_W;
         12'h004: return exp_ctype(m_aux);
         12'h100: return {31'b0, m_ctrl};
         12'h104: return m_aux;
         12'h108: return m_tag;
         12'h10C: return m_data;
         12'hC00: return m_flo;
         12'hC04: return m_fhi;
         default: return 32'h0;
      endcase
   endfunction

   function automatic bit exp_bad(input logic [11:0] o, input bit rd, input bit wr);
      bit rd_ok, wr_ok;
      rd_ok = is_store(o) || is_maint(o) || o == 12'h000 || o == 12'h004;
      wr_ok = is_store(o) || is_maint(o);
      return (rd && !rd_ok) || (wr && !wr_ok);
   endfunction

   function automatic string tag_of(input logic [11:0] o);
      if (o == 12'h000) return "R2";
      if (o == 12'h004) return "R6";
      if (o == 12'h100) return "R3";
      if (is_store(o))  return "R4";
      if (o >= 12'h730 && o <= 12'h7FF) return "R7";
      if (is_maint(o))  return "R8";
      return "R9";
   endfunction

   task automatic model_reset();
      m_ctrl = 1'b0; m_aux = AUX_R; m_tag = '0; m_data = '0; m_flo = '0; m_fhi = '0;
      last_rd = '0;
   endtask

   task automatic access(input logic [31:0] addr, input bit rd, input bit wr,
                         input logic [31:0] d, input string req);
      logic [31:0] er;
      bit          eb;
      logic [11:0] o;
      o = addr[11:0];
      @(negedge clk);
      bus_addr = addr; bus_rd = rd; bus_wr = wr; bus_wdata = d;
      er = exp_read(o);
      eb = exp_bad(o, rd, wr);
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0;
      if (rd) begin
         check(bus_rdata === er, req, bus_rdata, er);
         last_rd = er;
      end else begin
         check(bus_rdata === last_rd, "R10", bus_rdata, last_rd);
      end
      check(bad_access === eb, eb ? "R9" : req, {31'b0, bad_access}, {31'b0, eb});
      if (wr) begin
         case (o)
            12'h100: m_ctrl = d[0];
            12'h104: m_aux  = d;
            12'h108: m_tag  = d;
            12'h10C: m_data = d;
            12'hC00: m_flo  = d;
            12'hC04: m_fhi  = d;
            default: ;
         endcase
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      finish_run();
   end

   localparam int NPOOL = 16;
   function automatic logic [11:0] pool(input int unsigned k);
      case (k)
         0: return 12'h000;  1: return 12'h004;  2: return 12'h100;  3: return 12'h104;
         4: return 12'h108;  5: return 12'h10C;  6: return 12'hC00;  7: return 12'hC04;
         8: return 12'h730;  9: return 12'h7FF; 10: return 12'hF40; 11: return 12'hF60;
        12: return 12'hF80; 13: return 12'h800; 14: return 12'h72C;
         default: return 12'($urandom);
      endcase
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R5: outputs idle and reset values readable
      check(bus_rdata === 32'h0, "R5", bus_rdata, 32'h0);
      check(bad_access === 1'b0, "R5", {31'b0, bad_access}, 32'h0);
      access(32'h104, 1, 0, 0, "R5");
      access(32'h100, 1, 0, 0, "R5");
      access(32'h108, 1, 0, 0, "R5");
      access(32'h10C, 1, 0, 0, "R5");
      access(32'hC00, 1, 0, 0, "R5");
      access(32'hC04, 1, 0, 0, "R5");
      access(32'h004, 1, 0, 0, "R6");
      // R2 identity and write rejection
      access(32'h000, 1, 0, 0, "R2");
      access(32'h000, 0, 1, 32'hDEAD_BEEF, "R2");
      access(32'h000, 1, 0, 0, "R2");
      access(32'h004, 0, 1, 32'hFFFF_FFFF, "R6");
      // R3 enable bit only
      access(32'h100, 0, 1, 32'hFFFF_FFFF, "R3");
      access(32'h100, 1, 0, 0, "R3");
      access(32'h100, 0, 1, 32'hFFFF_FFFE, "R3");
      access(32'h100, 1, 0, 0, "R3");
      // R4 full-width words
      access(32'h108, 0, 1, 32'hA5A5_0F0F, "R4");
      access(32'h10C, 0, 1, 32'h1234_5678, "R4");
      access(32'hC00, 0, 1, 32'hFFFF_0000, "R4");
      access(32'hC04, 0, 1, 32'h0000_FFFF, "R4");
      access(32'h108, 1, 0, 0, "R4");
      access(32'h10C, 1, 0, 0, "R4");
      access(32'hC00, 1, 0, 0, "R4");
      access(32'hC04, 1, 0, 0, "R4");
      // R1 aliasing through upper address bits
      access(32'hABCD_E104, 0, 1, 32'h000F_0000, "R1");
      access(32'h5000_0104, 1, 0, 0, "R1");
      // R6 geometry packing follows current aux, never sticks
      access(32'h004, 1, 0, 0, "R6");
      access(32'h104, 0, 1, 32'h0000_0000, "R6");
      access(32'h004, 1, 0, 0, "R6");
      access(32'h104, 0, 1, 32'h0001_0000, "R6");
      access(32'h004, 1, 0, 0, "R6");
      // R7 maintenance window
      access(32'h730, 0, 1, 32'hFFFF_FFFF, "R7");
      access(32'h7FF, 1, 1, 32'h1111_1111, "R7");
      access(32'h7A0, 1, 0, 0, "R7");
      access(32'h104, 1, 0, 0, "R7");
      // R8 isolated maintenance offsets
      access(32'hF40, 0, 1, 32'hFFFF_FFFF, "R8");
      access(32'hF60, 1, 0, 0, "R8");
      access(32'hF80, 1, 1, 32'h2222_2222, "R8");
      // R9 holes next to mapped offsets
      access(32'h72F, 1, 0, 0, "R9");
      access(32'h800, 0, 1, 32'h3333_3333, "R9");
      access(32'h101, 1, 0, 0, "R9");
      access(32'hFFC, 1, 1, 32'h4444_4444, "R9");
      access(32'h104, 1, 0, 0, "R9");
      // R10 read-during-write returns old value, then the new one
      access(32'h108, 1, 1, 32'h0BAD_CAFE, "R10");
      access(32'h108, 1, 0, 0, "R10");
      access(32'h104, 1, 1, 32'h000A_0000, "R10");
      access(32'h004, 1, 0, 0, "R6");
      // constrained random mix
      for (int n = 0; n < 3000; n++) begin
         logic [11:0] o;
         logic [31:0] a;
         bit rd, wr;
         o  = pool($urandom % NPOOL);
         a  = {$urandom % 2 ? 20'($urandom) : 20'h0, o};
         rd = ($urandom % 3) != 0;
         wr = ($urandom % 2) == 1;
         access(a, rd, wr, $urandom, tag_of(o));
      end
      finish_run();
   end

endmodule